// File: doc/BRIEF.md
# Low-speed USB packet receiver

This block turns the two data lines of a low-speed USB link into a stream of decoded bytes. The line levels first pass through a synchronizer. A phase tracker then restarts its bit-period counter on every change of D-, so that each bit is sampled near its middle even when the far end's clock is slightly off. A small controller waits for the line to leave idle and recognises the sync field. It then hands each mid-bit sample to an NRZI decoder that also removes stuffed bits. An assembler collects the decoded bits into bytes, least significant bit first.

A packet ends when both lines are seen low at a sample point. Any bits collected since the last full byte are delivered as a final short byte, and a one-cycle end pulse reports how many bytes the packet produced. The assembler holds a budget of `BUF_BYTES` bytes per packet. When a byte would exceed that budget, the packet is abandoned with an overflow pulse and the rest of it is ignored. A start that never completes the sync field within `SYNC_TIMEOUT_BITS` samples is abandoned with a sync-error pulse.

The block is meant to feed a packet buffer. The byte strobe is the write enable and the end pulse commits the packet. The block does no PID, CRC or endpoint checking.

Top module: `usb_ls_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `byte_vld_o`, `eop_o`, `overflow_o` and `sync_err_o` are 0 and `byte_o` and `eop_count_o` are 0.
- R2: A J-to-K change of D- (J: D- high with D+ low; K: D+ high with D- low) starts sync detection. Data reception begins only after two consecutive mid-bit samples are both K. A K sample followed by a J sample does not start reception, and detection keeps going.
- R3: If sync detection has taken `SYNC_TIMEOUT_BITS` samples without seeing two consecutive K samples, `sync_err_o` pulses for one cycle, no byte or end pulse is produced, and the block waits for the next J-to-K change.
- R4: NRZI decoding: a data bit whose D- sample equals the previous sample decodes as 1, and one that differs decodes as 0. The last bit of the sync field (a K) is the reference for the first data bit.
- R5: After six consecutive decoded 1s, the next bit is dropped and does not reach the byte. The final 1 of the sync field counts towards this run.
- R6: Bits fill a byte from bit 0 upward. `byte_vld_o` is high for exactly one cycle per completed byte, with the byte on `byte_o` in that cycle.
- R7: A mid-bit sample with both D+ and D- low (SE0) ends the packet. `eop_o` pulses for one cycle, and `eop_count_o` then equals the number of `byte_vld_o` pulses in the packet.
- R8: If SE0 arrives after 1 to 7 bits of an unfinished byte, that byte is delivered on `byte_o` with the received bits in the low positions and zeros above them. It counts in `eop_count_o`.
- R9: At most `BUF_BYTES` bytes are delivered per packet. The next completed or partial byte produces a one-cycle `overflow_o` pulse instead of a byte strobe, with no `eop_o`. The rest of that packet up to its SE0 is ignored, and the following packet is received normally.
- R10: The sample point is re-aligned on every change of D-. Data bits lengthened or shortened by up to 3 clocks (at 8 clocks per bit) are decoded correctly.
- R11: `eop_o`, `overflow_o` and `sync_err_o` are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, about `CLKS_PER_BIT` cycles per line bit |
| rst_n | input | 1 | Active-low asynchronous reset |
| dp_i | input | 1 | D+ line level, asynchronous |
| dm_i | input | 1 | D- line level, asynchronous |
| byte_vld_o | output | 1 | One-cycle strobe, a decoded byte is on `byte_o` |
| byte_o | output | 8 | Decoded byte, bit 0 received first |
| eop_o | output | 1 | One-cycle pulse at the end of a packet |
| eop_count_o | output | $clog2(BUF_BYTES+1) | Bytes delivered in the packet, valid with `eop_o` |
| overflow_o | output | 1 | One-cycle pulse, packet abandoned because the byte budget ran out |
| sync_err_o | output | 1 | One-cycle pulse, sync field not completed in time |

## Verification
The bench builds the receiver with 8 clocks per bit, a byte budget of 4 and a sync window of 16 samples. The small budget lets ordinary short packets reach the overflow path, both on a full byte and on a trailing partial byte. It also makes the recovery packet after an overflow cheap. With 8 clocks per bit, shortening or lengthening the transition bits of the first byte by 2 or 3 clocks moves the line far enough that a free-running sample counter would drift, so the re-alignment on D- changes is exercised on real data.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SYNC,
      ST_DATA,
      ST_DRAIN
   } rx_state_e;

   typedef enum logic [1:0] {
      LN_SE0,
      LN_K,
      LN_J,
      LN_SE1
   } line_e;

   localparam int unsigned STUFF_RUN = 6;
   localparam int unsigned BYTE_BITS = 8;

   function automatic line_e line_of(input logic dp, input logic dm);
      line_e r;
      case ({dp, dm})
         2'b00:   r = LN_SE0;
         2'b10:   r = LN_K;
         2'b01:   r = LN_J;
         default: r = LN_SE1;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/usb_ls_line_sync.sv
module usb_ls_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dp_i,
   input  logic dm_i,
   output logic dp_o,
   output logic dm_o
);

   localparam int unsigned LANES = 2;
   localparam logic [LANES-1:0] REST = 2'b10;   // {dm, dp}: idle J

   if (STAGES < 2) begin : g_bad_stages
      $error("usb_ls_line_sync: STAGES must be at least 2");
   end

   logic [LANES-1:0] raw;
   logic [LANES-1:0] res;

   assign raw = {dm_i, dp_i};

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{REST[l]}};
         else        chain <= {chain[STAGES-2:0], raw[l]};
      end
      assign res[l] = chain[STAGES-1];
   end

   assign dp_o = res[0];
   assign dm_o = res[1];

endmodule

// File: rtl/usb_ls_phase_track.sv
module usb_ls_phase_track #(
   parameter int unsigned CLKS_PER_BIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dm_i,
   output logic edge_o,
   output logic smp_o
);

   localparam int unsigned PW = $clog2(CLKS_PER_BIT);
   localparam logic [PW-1:0] LAST = PW'(CLKS_PER_BIT - 1);
   localparam logic [PW-1:0] MID  = PW'(CLKS_PER_BIT / 2);
   localparam logic [PW-1:0] ONE  = PW'(1);

   if (CLKS_PER_BIT < 4) begin : g_bad_period
      $error("usb_ls_phase_track: CLKS_PER_BIT must be at least 4");
   end

   logic          dm_q;
   logic [PW-1:0] ph;

   assign edge_o = dm_i ^ dm_q;
   assign smp_o  = !edge_o && (ph == MID);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dm_q <= 1'b1;
         ph   <= '0;
      end else begin
         dm_q <= dm_i;
         if (edge_o)          ph <= ONE;
         else if (ph == LAST) ph <= '0;
         else                 ph <= ph + ONE;
      end
   end

endmodule

// File: rtl/usb_ls_nrzi_unstuff.sv
module usb_ls_nrzi_unstuff
   import usb_ls_rx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic smp_i,
   input  logic dm_i,
   output logic bit_vld_o,
   output logic bit_o
);

   localparam logic [2:0] RUN_MAX = 3'(STUFF_RUN);

   logic       prev_dm;
   logic [2:0] run;
   logic       stuffed;

   assign stuffed   = (run == RUN_MAX);
   assign bit_o     = (dm_i == prev_dm);
   assign bit_vld_o = smp_i && !stuffed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_dm <= 1'b0;
         run     <= '0;
      end else if (arm_i) begin
         prev_dm <= 1'b0;          // last sync bit is K
         run     <= 3'd1;          // and decodes as 1
      end else if (smp_i) begin
         prev_dm <= dm_i;
         if (stuffed)    run <= '0;
         else if (bit_o) run <= run + 3'd1;
         else            run <= '0;
      end
   end

endmodule

// File: rtl/usb_ls_byte_pack.sv
module usb_ls_byte_pack
   import usb_ls_rx_pkg::*;
#(
   parameter int unsigned BUF_BYTES = 11,
   parameter int unsigned CW        = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          bit_vld_i,
   input  logic          bit_i,
   input  logic          flush_i,
   output logic          byte_vld_o,
   output logic [7:0]    byte_o,
   output logic          eop_o,
   output logic [CW-1:0] eop_count_o,
   output logic          overflow_o
);

   localparam logic [2:0]    LAST_IDX = 3'(BYTE_BITS - 1);
   localparam logic [CW-1:0] BUDGET   = CW'(BUF_BYTES);

   logic [7:0]    acc;
   logic [7:0]    acc_nxt;
   logic [2:0]    idx;
   logic [CW-1:0] left;
   logic [CW-1:0] cnt;
   logic          roomy;

   assign acc_nxt = acc | ({7'd0, bit_i} << idx);
   assign roomy   = (left != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc         <= '0;
         idx         <= '0;
         left        <= '0;
         cnt         <= '0;
         byte_vld_o  <= 1'b0;
         byte_o      <= '0;
         eop_o       <= 1'b0;
         eop_count_o <= '0;
         overflow_o  <= 1'b0;
      end else begin
         byte_vld_o <= 1'b0;
         eop_o      <= 1'b0;
         overflow_o <= 1'b0;
         if (clr_i) begin
            acc  <= '0;
            idx  <= '0;
            left <= BUDGET;
            cnt  <= '0;
         end else if (flush_i) begin
            if (idx != '0 && !roomy) begin
               overflow_o <= 1'b1;
            end else begin
               if (idx != '0) begin
                  byte_vld_o  <= 1'b1;
                  byte_o      <= acc;
                  eop_count_o <= cnt + 1'b1;
               end else begin
                  eop_count_o <= cnt;
               end
               eop_o <= 1'b1;
            end
            acc <= '0;
            idx <= '0;
         end else if (bit_vld_i) begin
            if (idx == LAST_IDX) begin
               acc <= '0;
               idx <= '0;
               if (roomy) begin
                  byte_vld_o <= 1'b1;
                  byte_o     <= acc_nxt;
                  left       <= left - 1'b1;
                  cnt        <= cnt + 1'b1;
               end else begin
                  overflow_o <= 1'b1;
               end
            end else begin
               acc <= acc_nxt;
               idx <= idx + 3'd1;
            end
         end
      end
   end

endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
   import usb_ls_rx_pkg::*;
#(
   parameter int unsigned CLKS_PER_BIT      = 8,
   parameter int unsigned BUF_BYTES         = 11,
   parameter int unsigned SYNC_TIMEOUT_BITS = 16,
   parameter int unsigned SYNC_STAGES       = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           dp_i,
   input  logic                           dm_i,
   output logic                           byte_vld_o,
   output logic [7:0]                     byte_o,
   output logic                           eop_o,
   output logic [$clog2(BUF_BYTES+1)-1:0] eop_count_o,
   output logic                           overflow_o,
   output logic                           sync_err_o
);

   localparam int unsigned CW = $clog2(BUF_BYTES + 1);
   localparam int unsigned TW = $clog2(SYNC_TIMEOUT_BITS + 1);
   localparam logic [TW-1:0] TMO_LAST = TW'(SYNC_TIMEOUT_BITS - 1);

   if (BUF_BYTES < 1) begin : g_bad_buf
      $error("usb_ls_rx: BUF_BYTES must be at least 1");
   end
   if (SYNC_TIMEOUT_BITS < 9) begin : g_bad_tmo
      $error("usb_ls_rx: SYNC_TIMEOUT_BITS must cover a whole sync field");
   end

   logic      dp_s, dm_s;
   logic      dm_edge, smp;
   line_e     ln;
   rx_state_e state;
   logic      prev_k;
   logic [TW-1:0] tmo_cnt;
   logic      arm, data_smp, flush;
   logic      bit_vld, bit_val;

   usb_ls_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .dp_i (dp_i),
      .dm_i (dm_i),
      .dp_o (dp_s),
      .dm_o (dm_s)
   );

   usb_ls_phase_track #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .dm_i  (dm_s),
      .edge_o(dm_edge),
      .smp_o (smp)
   );

   assign ln       = line_of(dp_s, dm_s);
   assign arm      = (state == ST_SYNC) && smp && (ln == LN_K) && prev_k;
   assign data_smp = (state == ST_DATA) && smp && (ln != LN_SE0);
   assign flush    = (state == ST_DATA) && smp && (ln == LN_SE0);

   usb_ls_nrzi_unstuff u_nrzi (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm_i    (arm),
      .smp_i    (data_smp),
      .dm_i     (dm_s),
      .bit_vld_o(bit_vld),
      .bit_o    (bit_val)
   );

   usb_ls_byte_pack #(.BUF_BYTES(BUF_BYTES), .CW(CW)) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (arm),
      .bit_vld_i  (bit_vld),
      .bit_i      (bit_val),
      .flush_i    (flush),
      .byte_vld_o (byte_vld_o),
      .byte_o     (byte_o),
      .eop_o      (eop_o),
      .eop_count_o(eop_count_o),
      .overflow_o (overflow_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         prev_k     <= 1'b0;
         tmo_cnt    <= '0;
         sync_err_o <= 1'b0;
      end else begin
         sync_err_o <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (dm_edge && ln == LN_K) begin
                  state   <= ST_SYNC;
                  prev_k  <= 1'b0;
                  tmo_cnt <= '0;
               end
            end
            ST_SYNC: begin
               if (smp) begin
                  if (ln == LN_K && prev_k) begin
                     state <= ST_DATA;
                  end else if (tmo_cnt == TMO_LAST) begin
                     sync_err_o <= 1'b1;
                     state      <= ST_IDLE;
                  end else begin
                     prev_k  <= (ln == LN_K);
                     tmo_cnt <= tmo_cnt + 1'b1;
                  end
               end
            end
            ST_DATA: begin
               if (overflow_o)  state <= ST_DRAIN;
               else if (flush)  state <= ST_IDLE;
            end
            ST_DRAIN: begin
               if (ln == LN_SE0) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/usb_ls_rx_checker.sv
module usb_ls_rx_checker #(
   parameter int unsigned BUF_BYTES = 11
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           byte_vld_o,
   input logic                           eop_o,
   input logic [$clog2(BUF_BYTES+1)-1:0] eop_count_o,
   input logic                           overflow_o,
   input logic                           sync_err_o
);

   p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({eop_o, overflow_o, sync_err_o}));

   p_eop_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      eop_o |=> !eop_o);

   p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      eop_o |-> (eop_count_o <= BUF_BYTES));

   p_byte_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |=> !byte_vld_o);

   p_no_byte_on_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o |-> !byte_vld_o);

   p_ovf_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o |=> !overflow_o);

   p_serr_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sync_err_o |-> !byte_vld_o);

   p_serr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sync_err_o |=> !sync_err_o);

endmodule

bind usb_ls_rx usb_ls_rx_checker #(.BUF_BYTES(BUF_BYTES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .byte_vld_o (byte_vld_o),
   .eop_o      (eop_o),
   .eop_count_o(eop_count_o),
   .overflow_o (overflow_o),
   .sync_err_o (sync_err_o)
);

// File: tb/tb_usb_ls_rx.sv
module tb_usb_ls_rx;

   localparam int CLK_PERIOD = 10;
   localparam int CPB        = 8;
   localparam int BUF        = 4;
   localparam int TMO        = 16;
   localparam int CW         = $clog2(BUF + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dp_r = 1'b0;
   logic          dm_r = 1'b1;
   logic          byte_vld_o, eop_o, overflow_o, sync_err_o;
   logic [7:0]    byte_o;
   logic [CW-1:0] eop_count_o;

   usb_ls_rx #(.CLKS_PER_BIT(CPB), .BUF_BYTES(BUF), .SYNC_TIMEOUT_BITS(TMO),
               .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .dp_i(dp_r), .dm_i(dm_r),
      .byte_vld_o(byte_vld_o), .byte_o(byte_o), .eop_o(eop_o),
      .eop_count_o(eop_count_o), .overflow_o(overflow_o), .sync_err_o(sync_err_o)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [7:0]    got [16];
   int            got_n, eop_n, ovf_n, serr_n;
   logic [CW-1:0] eop_cnt_seen;

   always @(negedge clk) begin
      if (rst_n) begin
         if (byte_vld_o) begin
            if (got_n < 16) got[got_n] = byte_o;
            got_n++;
         end
         if (eop_o) begin
            eop_n++;
            eop_cnt_seen = eop_count_o;
         end
         if (overflow_o) ovf_n++;
         if (sync_err_o) serr_n++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      got_n = 0; eop_n = 0; ovf_n = 0; serr_n = 0; eop_cnt_seen = '0;
   endtask

   logic [7:0] pkt [8];
   int         pkt_n;
   int         part_bits;
   logic [7:0] part_val;
   int         fast_delta;
   bit         false_k;
   logic       cur_j;

   task automatic put(input logic dp, input logic dm, input int n);
      dp_r = dp;
      dm_r = dm;
      repeat (n) @(negedge clk);
   endtask

   task automatic tx_bit(input bit b, input int len);
      if (!b) cur_j = ~cur_j;
      put(!cur_j, cur_j, len);
   endtask

   task automatic send();
      int ones;
      cur_j = 1'b1;
      put(1'b0, 1'b1, 4 * CPB);
      if (false_k) begin
         put(1'b1, 1'b0, CPB);
         put(1'b0, 1'b1, 3 * CPB);
      end
      for (int i = 0; i < 7; i++) tx_bit(1'b0, CPB);
      tx_bit(1'b1, CPB);
      ones = 1;
      for (int b = 0; b < pkt_n; b++) begin
         for (int i = 0; i < 8; i++) begin
            bit v;
            v = pkt[b][i];
            tx_bit(v, CPB + ((b == 0 && !v) ? fast_delta : 0));
            ones = v ? ones + 1 : 0;
            if (ones == 6) begin
               tx_bit(1'b0, CPB);
               ones = 0;
            end
         end
      end
      for (int i = 0; i < part_bits; i++) begin
         bit v;
         v = part_val[i];
         tx_bit(v, CPB);
         ones = v ? ones + 1 : 0;
         if (ones == 6) begin
            tx_bit(1'b0, CPB);
            ones = 0;
         end
      end
      put(1'b0, 1'b0, 2 * CPB);
      cur_j = 1'b1;
      put(1'b0, 1'b1, 6 * CPB);
   endtask

   function automatic logic [7:0] part_expect(input logic [7:0] v, input int n);
      return v & 8'((1 << n) - 1);
   endfunction

   task automatic expect_pkt(input string req);
      int total;
      total = pkt_n + ((part_bits > 0) ? 1 : 0);
      chk(serr_n == 0, req, serr_n, 0);
      if (total <= BUF) begin
         chk(got_n == total, req, got_n, total);
         chk(eop_n == 1, req, eop_n, 1);
         chk(int'(eop_cnt_seen) == total, req, int'(eop_cnt_seen), total);
         chk(ovf_n == 0, req, ovf_n, 0);
         for (int i = 0; i < pkt_n && i < got_n; i++)
            chk(got[i] == pkt[i], req, got[i], pkt[i]);
         if (part_bits > 0 && got_n > pkt_n)
            chk(got[pkt_n] == part_expect(part_val, part_bits), req,
                got[pkt_n], part_expect(part_val, part_bits));
      end else begin
         chk(got_n == BUF, req, got_n, BUF);
         chk(ovf_n == 1, req, ovf_n, 1);
         chk(eop_n == 0, req, eop_n, 0);
         for (int i = 0; i < BUF && i < got_n; i++)
            chk(got[i] == pkt[i], req, got[i], pkt[i]);
      end
   endtask

   task automatic run_pkt(input string req);
      clear_mon();
      send();
      expect_pkt(req);
      part_bits = 0; fast_delta = 0; false_k = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      part_bits = 0; fast_delta = 0; false_k = 1'b0; cur_j = 1'b1;
      clear_mon();
      repeat (4) @(negedge clk);
      // R1: quiet outputs in reset and just after release
      chk({byte_vld_o, eop_o, overflow_o, sync_err_o} == 4'b0, "R1", 1, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({byte_vld_o, eop_o, overflow_o, sync_err_o} == 4'b0, "R1", 1, 0);
      chk(byte_o == 8'h00 && eop_count_o == '0, "R1", int'(byte_o), 0);
      put(1'b0, 1'b1, 4 * CPB);

      // R4 R5 R6 R7: transitions only, long runs with stuffing, mixed
      pkt[0] = 8'h00; pkt[1] = 8'hFF; pkt[2] = 8'h7E; pkt[3] = 8'h3F; pkt_n = 4;
      run_pkt("R4 R5 R6 R7");

      // R8: partial byte of 3 bits
      pkt[0] = 8'hA5; pkt_n = 1; part_bits = 3; part_val = 8'h06;
      run_pkt("R8");
      // R8 R5: partial of 7 ones, stuffed bit before SE0
      pkt[0] = 8'h80; pkt_n = 1; part_bits = 7; part_val = 8'h7F;
      run_pkt("R8 R5");

      // R9: too many full bytes, then a normal packet
      for (int i = 0; i < 6; i++) pkt[i] = 8'($urandom);
      pkt_n = 6;
      run_pkt("R9");
      pkt[0] = 8'h5A; pkt_n = 1;
      run_pkt("R9 recovery");
      // R9: budget used up, partial byte overflows
      for (int i = 0; i < 4; i++) pkt[i] = 8'(8'h11 * (i + 1));
      pkt_n = 4; part_bits = 2; part_val = 8'h03;
      run_pkt("R9 partial");

      // R2: lone K before the real sync
      pkt[0] = 8'hC3; pkt[1] = 8'h01; pkt_n = 2; false_k = 1'b1;
      run_pkt("R2");

      // R3: K edge never followed by a sync field
      clear_mon();
      put(1'b0, 1'b1, 4 * CPB);
      put(1'b1, 1'b0, CPB);
      put(1'b0, 1'b1, (TMO + 4) * CPB);
      chk(serr_n == 1, "R3", serr_n, 1);
      chk(got_n == 0 && eop_n == 0, "R3", got_n + eop_n, 0);
      pkt[0] = 8'h96; pkt_n = 1;
      run_pkt("R3 recovery");

      // R10: transition bits of the first byte shortened and lengthened
      pkt[0] = 8'h00; pkt[1] = 8'hC3; pkt_n = 2; fast_delta = -3;
      run_pkt("R10 short");
      pkt[0] = 8'h00; pkt[1] = 8'h3C; pkt_n = 2; fast_delta = 3;
      run_pkt("R10 long");

      // R4 R5 R6 R7 R8 R10: constrained random packets
      for (int n = 0; n < 24; n++) begin
         int sel;
         pkt_n = 1 + int'($urandom % BUF);
         for (int i = 0; i < pkt_n; i++)
            pkt[i] = (($urandom % 4) == 0) ? 8'hFF : 8'($urandom);
         part_bits = (($urandom % 3) == 0) ? 1 + int'($urandom % 7) : 0;
         part_val  = 8'($urandom);
         sel = int'($urandom % 3);
         fast_delta = (sel == 0) ? 0 : ((sel == 1) ? -2 : 2);
         run_pkt("R4 R5 R6 R7 R8 R10 random");
      end

      finish_run();
   end

endmodule